// File: doc/BRIEF.md
# Scrolling Viewport Burst Address Generator

This block tells an SDRAM read controller where each video line's full-page burst should start, so that a 640x480 window can be moved over a larger stored picture. The stored area has two margins around the window. A 16-word scroll margin lies directly around it, and a 16-word entry zone for moving objects lies outside that. The window therefore starts 32 words and 32 rows in from the stored-area origin. The block moves the window by shifting the burst's starting column and the row it reads. Column addresses wrap inside a 1024-word page.

A separate 800-clock by 521-line timing generator drives the horizontal and line counts into the block. Two scroll offsets are taken once per frame, at the very first count of the frame. Each offset is limited to the 32 words of guard space. On every visible line the block issues a one-clock burst request together with that line's row and column address. Later in the same line it issues a one-clock write-phase strobe. On lines outside the visible window it stays silent and keeps the last address.

Top module: `vpBurstAddr`

## Requirements
- R1: While rstN is low at a rising clk edge, burstReq and writeStart are 0 and colAddr and rowAddr are all zeros after that edge.
- R2: burstReq is high for exactly one clock. That clock is the one after a cycle in which hCount equals 142 and vCount lies between 31 and 510 inclusive.
- R3: writeStart is high for exactly one clock. That clock is the one after a cycle in which hCount equals 781 and vCount lies between 31 and 510 inclusive.
- R4: When vCount is below 31 or above 510, neither strobe is raised. colAddr and rowAddr keep the values of the last burst.
- R5: In the burstReq cycle, colAddr equals (COL_BASE + 32 + latched X offset) modulo 1024, so the address wraps at the page boundary.
- R6: In the burstReq cycle, rowAddr equals ROW_BASE + 32 + latched Y offset + (vCount − 31), where vCount is the value in the cycle that triggered the burst.
- R7: An offset input above 32 is latched as 32. Values from 0 to 32 are latched unchanged.
- R8: The offsets are sampled only in a cycle in which vCount is 0 and hCount is 0. Offset changes at any other time, including the cycle that triggers a burst, have no effect until the next such cycle.
- R9: colAddr and rowAddr change only in a cycle in which burstReq is high, and keep their value through the write-phase strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous reset, active low |
| hCount | input | 10 | Horizontal pixel count, 0..799, from the timing generator |
| vCount | input | 10 | Line count, 0..520, from the timing generator |
| xOfs | input | 6 | Requested horizontal scroll offset in words |
| yOfs | input | 6 | Requested vertical scroll offset in lines |
| burstReq | output | 1 | One-clock request to start a page read burst |
| writeStart | output | 1 | One-clock strobe marking the start of the write phase |
| colAddr | output | 10 | Burst start column within the 1024-word page |
| rowAddr | output | 13 | Row to read for the current line |

## Verification
Two functions can meet in a single clock: the address computation for a visible line, and a change on the scroll offset inputs. The bench changes both offsets in exactly the cycle in which hCount is 142 on a visible line. The request that follows must still carry the column and row built from the offsets latched at frame start. The offsets are also changed on line 0 away from horizontal count 0, and must be ignored there. Each strobe is matched against a queued expectation that records the clock it must appear in, so a strobe that is late, early, missing or stray, or that carries the wrong address, is reported.

// File: rtl/vpb_pkg.sv
package vpb_pkg;

  // Decoded events handed from the control decoder to the datapath.
  typedef struct packed {
    logic latchOfs;   // frame start: capture scroll offsets
    logic issueReq;   // visible line, burst-request count reached
    logic issueWr;    // visible line, write-phase count reached
  } vpbStrobes_t;

endpackage

// File: rtl/vpbControl.sv
module vpbControl
  import vpb_pkg::*;
#(
  parameter int HC_W    = 10,
  parameter int VC_W    = 10,
  parameter int REQ_H   = 142,
  parameter int WR_H    = 781,
  parameter int V_FIRST = 31,
  parameter int V_LAST  = 510
) (
  input  logic [HC_W-1:0] hCount,
  input  logic [VC_W-1:0] vCount,
  output vpbStrobes_t     stb
);

  localparam logic [HC_W-1:0] REQ_H_C   = HC_W'(REQ_H);
  localparam logic [HC_W-1:0] WR_H_C    = HC_W'(WR_H);
  localparam logic [VC_W-1:0] V_FIRST_C = VC_W'(V_FIRST);
  localparam logic [VC_W-1:0] V_LAST_C  = VC_W'(V_LAST);

  logic visLine;
  logic frameTop;

  always_comb begin
    visLine  = (vCount >= V_FIRST_C) && (vCount <= V_LAST_C);
    frameTop = (vCount == '0) && (hCount == '0);
    stb.latchOfs = frameTop;
    stb.issueReq = visLine && (hCount == REQ_H_C);
    stb.issueWr  = visLine && (hCount == WR_H_C);
  end

endmodule

// File: rtl/vpbDatapath.sv
module vpbDatapath
  import vpb_pkg::*;
#(
  parameter int VC_W     = 10,
  parameter int OFS_W    = 6,
  parameter int COL_W    = 10,
  parameter int ROW_W    = 13,
  parameter int V_FIRST  = 31,
  parameter int SCROLL_M = 16,
  parameter int ENTRY_M  = 16,
  parameter int COL_BASE = 0,
  parameter int ROW_BASE = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  vpbStrobes_t      stb,
  input  logic [VC_W-1:0]  vCount,
  input  logic [OFS_W-1:0] xOfs,
  input  logic [OFS_W-1:0] yOfs,
  output logic             burstReq,
  output logic             writeStart,
  output logic [COL_W-1:0] colAddr,
  output logic [ROW_W-1:0] rowAddr
);

  localparam int LEAD    = SCROLL_M + ENTRY_M;
  localparam int MAX_OFS = 2 * SCROLL_M;
  localparam logic [COL_W-1:0] COL_ORIGIN = COL_W'((COL_BASE + LEAD) % (2 ** COL_W));
  localparam logic [ROW_W-1:0] ROW_ORIGIN = ROW_W'(ROW_BASE + LEAD);
  localparam logic [OFS_W-1:0] OFS_CAP    = OFS_W'(MAX_OFS);
  localparam logic [VC_W-1:0]  V_FIRST_C  = VC_W'(V_FIRST);

  logic [OFS_W-1:0] xLat, yLat;
  logic [VC_W-1:0]  lineIdx;
  logic [COL_W-1:0] colNext;
  logic [ROW_W-1:0] rowNext;

  function automatic logic [OFS_W-1:0] clampOfs(input logic [OFS_W-1:0] raw);
    return (raw > OFS_CAP) ? OFS_CAP : raw;
  endfunction

  // Column truncates to COL_W bits: that is the page wrap.
  always_comb begin
    lineIdx = vCount - V_FIRST_C;
    colNext = COL_ORIGIN + {{(COL_W-OFS_W){1'b0}}, xLat};
    rowNext = ROW_ORIGIN + {{(ROW_W-OFS_W){1'b0}}, yLat}
                         + {{(ROW_W-VC_W){1'b0}}, lineIdx};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xLat       <= '0;
      yLat       <= '0;
      burstReq   <= 1'b0;
      writeStart <= 1'b0;
      colAddr    <= '0;
      rowAddr    <= '0;
    end else begin
      if (stb.latchOfs) begin
        xLat <= clampOfs(xOfs);
        yLat <= clampOfs(yOfs);
      end
      burstReq   <= stb.issueReq;
      writeStart <= stb.issueWr;
      if (stb.issueReq) begin
        colAddr <= colNext;
        rowAddr <= rowNext;
      end
    end
  end

endmodule

// File: rtl/vpBurstAddr.sv
module vpBurstAddr
  import vpb_pkg::*;
#(
  parameter int H_TOTAL    = 800,
  parameter int V_TOTAL    = 521,
  parameter int REQ_H      = 142,
  parameter int WR_H       = 781,
  parameter int V_FIRST    = 31,
  parameter int V_LAST     = 510,
  parameter int PAGE_WORDS = 1024,
  parameter int SCROLL_M   = 16,
  parameter int ENTRY_M    = 16,
  parameter int OFS_W      = 6,
  parameter int ROW_W      = 13,
  parameter int COL_BASE   = 0,
  parameter int ROW_BASE   = 0,
  localparam int HC_W      = $clog2(H_TOTAL),
  localparam int VC_W      = $clog2(V_TOTAL),
  localparam int COL_W     = $clog2(PAGE_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [HC_W-1:0]  hCount,
  input  logic [VC_W-1:0]  vCount,
  input  logic [OFS_W-1:0] xOfs,
  input  logic [OFS_W-1:0] yOfs,
  output logic             burstReq,
  output logic             writeStart,
  output logic [COL_W-1:0] colAddr,
  output logic [ROW_W-1:0] rowAddr
);

  vpbStrobes_t stb;

  vpbControl #(
    .HC_W(HC_W), .VC_W(VC_W), .REQ_H(REQ_H), .WR_H(WR_H),
    .V_FIRST(V_FIRST), .V_LAST(V_LAST)
  ) u_ctl (
    .hCount(hCount), .vCount(vCount), .stb(stb)
  );

  vpbDatapath #(
    .VC_W(VC_W), .OFS_W(OFS_W), .COL_W(COL_W), .ROW_W(ROW_W),
    .V_FIRST(V_FIRST), .SCROLL_M(SCROLL_M), .ENTRY_M(ENTRY_M),
    .COL_BASE(COL_BASE), .ROW_BASE(ROW_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .vCount(vCount),
    .xOfs(xOfs), .yOfs(yOfs),
    .burstReq(burstReq), .writeStart(writeStart),
    .colAddr(colAddr), .rowAddr(rowAddr)
  );

endmodule

// File: rtl/vpbChecker.sv
module vpbChecker #(
  parameter int HC_W     = 10,
  parameter int VC_W     = 10,
  parameter int COL_W    = 10,
  parameter int ROW_W    = 13,
  parameter int REQ_H    = 142,
  parameter int WR_H     = 781,
  parameter int V_FIRST  = 31,
  parameter int V_LAST   = 510,
  parameter int SCROLL_M = 16,
  parameter int ENTRY_M  = 16,
  parameter int COL_BASE = 0,
  parameter int ROW_BASE = 0
) (
  input logic             clk,
  input logic             rstN,
  input logic [HC_W-1:0]  hCount,
  input logic [VC_W-1:0]  vCount,
  input logic             burstReq,
  input logic             writeStart,
  input logic [COL_W-1:0] colAddr,
  input logic [ROW_W-1:0] rowAddr
);

  localparam logic [COL_W-1:0] COL_ORG  = COL_W'((COL_BASE + SCROLL_M + ENTRY_M) % (2 ** COL_W));
  localparam logic [ROW_W-1:0] ROW_ORG  = ROW_W'(ROW_BASE + SCROLL_M + ENTRY_M);
  localparam logic [COL_W-1:0] COL_SPAN = COL_W'(2 * SCROLL_M);
  localparam logic [ROW_W-1:0] ROW_SPAN = ROW_W'(2 * SCROLL_M + V_LAST - V_FIRST);

  logic inWin, reqHit, wrHit;
  logic [COL_W-1:0] colRel;
  logic [ROW_W-1:0] rowRel;
  assign inWin  = (vCount >= VC_W'(V_FIRST)) && (vCount <= VC_W'(V_LAST));
  assign reqHit = inWin && (hCount == HC_W'(REQ_H));
  assign wrHit  = inWin && (hCount == HC_W'(WR_H));
  assign colRel = colAddr - COL_ORG;
  assign rowRel = rowAddr - ROW_ORG;

  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) reqHit |=> burstReq) else $error("AST_REQ_FOLLOWS"); // R2
  AST_REQ_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN) burstReq |=> !burstReq) else $error("AST_REQ_ONE_CLK"); // R2
  AST_WR_FOLLOWS:  assert property (@(posedge clk) disable iff (!rstN) wrHit |=> writeStart) else $error("AST_WR_FOLLOWS"); // R3
  AST_NO_STRAY_REQ: assert property (@(posedge clk) disable iff (!rstN) !reqHit |=> !burstReq) else $error("AST_NO_STRAY_REQ"); // R4
  AST_NO_STRAY_WR: assert property (@(posedge clk) disable iff (!rstN) !wrHit |=> !writeStart) else $error("AST_NO_STRAY_WR"); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN) (!burstReq && $past(rstN)) |-> ($stable(colAddr) && $stable(rowAddr))) else $error("AST_ADDR_HOLD"); // R9
  AST_COL_IN_MARGIN: assert property (@(posedge clk) disable iff (!rstN) burstReq |-> (colRel <= COL_SPAN)) else $error("AST_COL_IN_MARGIN"); // R7
  AST_ROW_IN_AREA: assert property (@(posedge clk) disable iff (!rstN) burstReq |-> (rowRel <= ROW_SPAN)) else $error("AST_ROW_IN_AREA"); // R6

endmodule

bind vpBurstAddr vpbChecker #(
  .HC_W(HC_W), .VC_W(VC_W), .COL_W(COL_W), .ROW_W(ROW_W),
  .REQ_H(REQ_H), .WR_H(WR_H), .V_FIRST(V_FIRST), .V_LAST(V_LAST),
  .SCROLL_M(SCROLL_M), .ENTRY_M(ENTRY_M),
  .COL_BASE(COL_BASE), .ROW_BASE(ROW_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .hCount(hCount), .vCount(vCount),
  .burstReq(burstReq), .writeStart(writeStart),
  .colAddr(colAddr), .rowAddr(rowAddr)
);

// File: tb/tb_vpBurstAddr.sv
`timescale 1ns/1ps
module tb_vpBurstAddr;

  localparam int COL_BASE = 980;
  localparam int ROW_BASE = 100;
  localparam int REQ_H = 142;
  localparam int WR_H  = 781;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] hCount = '0;
  logic [9:0] vCount = '0;
  logic [5:0] xOfs = '0;
  logic [5:0] yOfs = '0;
  logic burstReq, writeStart;
  logic [9:0] colAddr;
  logic [12:0] rowAddr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    bit    isReq;
    int    due;
    int    col;
    int    row;
    string colTag;
  } ev_t;
  ev_t expQ[$];

  int expX = 0, expY = 0;
  int lastCol = 0, lastRow = 0;

  vpBurstAddr #(.COL_BASE(COL_BASE), .ROW_BASE(ROW_BASE)) dut (
    .clk(clk), .rstN(rstN), .hCount(hCount), .vCount(vCount),
    .xOfs(xOfs), .yOfs(yOfs), .burstReq(burstReq), .writeStart(writeStart),
    .colAddr(colAddr), .rowAddr(rowAddr)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int capOfs(input int v);
    return (v > 32) ? 32 : v;
  endfunction

  // Monitor: every strobe must match the head of the queue.
  task automatic takeEvent(input bit isReq);
    ev_t e;
    if (expQ.size() == 0) begin
      check(0, "R4 stray strobe", int'(isReq), -1);
      return;
    end
    e = expQ.pop_front();
    check(e.isReq == isReq, isReq ? "R2 strobe kind" : "R3 strobe kind", int'(isReq), int'(e.isReq));
    check(e.due == cyc, isReq ? "R2 strobe cycle" : "R3 strobe cycle", cyc, e.due);
    check(int'(colAddr) == e.col, isReq ? e.colTag : "R9 column held", int'(colAddr), e.col);
    check(int'(rowAddr) == e.row, isReq ? "R6 row" : "R9 row held", int'(rowAddr), e.row);
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (burstReq) takeEvent(1'b1);
      if (writeStart) takeEvent(1'b0);
    end
  end

  task automatic frameStart(input int x, input int y);
    @(posedge clk); #1;
    hCount = 0; vCount = 0; xOfs = 6'(x); yOfs = 6'(y);
    expX = capOfs(x); expY = capOfs(y);
    @(posedge clk); #1;
    hCount = 1;
  endtask

  // Drives one full line; optionally changes offsets in the request cycle.
  task automatic runLine(input int v, input bit chg, input int nx, input int ny, input string colTag);
    bit vis = (v >= 31) && (v <= 510);
    for (int h = 0; h < 800; h++) begin
      @(posedge clk); #1;
      hCount = 10'(h); vCount = 10'(v);
      if (chg && h == REQ_H) begin xOfs = 6'(nx); yOfs = 6'(ny); end
      if (vis && h == REQ_H) begin
        lastCol = (COL_BASE + 32 + expX) % 1024;
        lastRow = ROW_BASE + 32 + expY + (v - 31);
        expQ.push_back('{1'b1, cyc + 1, lastCol, lastRow, colTag});
      end
      if (vis && h == WR_H) expQ.push_back('{1'b0, cyc + 1, lastCol, lastRow, "R9"});
    end
  endtask

  task automatic checkHold(input string tag);
    @(negedge clk);
    check(int'(colAddr) == lastCol, tag, int'(colAddr), lastCol);
    check(int'(rowAddr) == lastRow, tag, int'(rowAddr), lastRow);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(burstReq == 1'b0, "R1 burstReq", int'(burstReq), 0);
    check(writeStart == 1'b0, "R1 writeStart", int'(writeStart), 0);
    check(colAddr == '0, "R1 colAddr", int'(colAddr), 0);
    check(rowAddr == '0, "R1 rowAddr", int'(rowAddr), 0);
    @(posedge clk); #1;
    rstN = 1'b1;

    // Unscrolled frame, first and last visible lines
    frameStart(0, 0);
    runLine(31, 0, 0, 0, "R5 column");
    runLine(510, 0, 0, 0, "R5 column");
    // Non-visible lines: silent, address held (R4)
    runLine(511, 0, 0, 0, "R4");
    runLine(520, 0, 0, 0, "R4");
    runLine(30, 0, 0, 0, "R4");
    checkHold("R4 hold after blank lines");

    // Column wraps at the page end; offset change in the request cycle ignored (R8)
    frameStart(12, 5);
    runLine(31, 1, 3, 3, "R5 page wrap");
    runLine(100, 0, 0, 0, "R8 mid-frame change ignored");

    // Oversized offsets clamp to 32 (R7)
    frameStart(50, 63);
    runLine(31, 0, 0, 0, "R7 clamp");
    // Exactly 32 passes unchanged (R7)
    frameStart(32, 32);
    runLine(200, 0, 0, 0, "R7 limit value");

    // Line 0 away from hCount 0 must not resample (R8)
    @(posedge clk); #1;
    hCount = 5; vCount = 0; xOfs = 6'd7; yOfs = 6'd7;
    @(posedge clk); #1;
    hCount = 6;
    runLine(31, 0, 0, 0, "R8 line 0 late change ignored");
    checkHold("R9 hold after line");

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R2 missing strobes", expQ.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule